// File: doc/BRIEF.md
# Hierarchical Weighted Memory Request Arbiter

This block picks which memory client is served next. The clients sit on a chain of levels. At each level the arbiter divides grants between that level's own client and everything that hangs below it. The division follows two programmable weights for the level. When the local client is idle, its share falls through to the branch beneath it, so bandwidth that one client does not use is taken by the clients further down.

A decision is made only when the memory controller raises a one-cycle arbitration-point strobe, which it does once the current transaction is finished. The result is a registered one-hot grant vector and a grant-valid pulse that are both presented in the following cycle.

The default chain has three levels. One designated level carries two clients that share its local slot. A single tail client sits below the last level.

Top module: `hier_arb`

## Requirements
- R1: While reset is high and in the cycle after it, `grant` is all zeros and `grantValid` is low.
- R2: `grant` changes only in the cycle after `arbPoint` is high, and holds at all other times. `grantValid` is high for exactly the one cycle after a strobe that produced a grant.
- R3: A strobe with no enabled client requesting drives `grant` to all zeros with `grantValid` low.
- R4: Client numbering is fixed:
  - Bit i of `clientReq`, `clientEn` and `grant` (for i < NUM_LEVELS) is the own client of level i, with level 0 at the top.
  - Bit NUM_LEVELS is the second client of level SHARED_LEVEL.
  - Bit NUM_LEVELS+1 is the tail client below the last level.
  - `grant` is one-hot or zero, and a granted client was requesting and enabled at the strobe.
- R5: At a level where only one side (own client or lower branch) has a request, that side wins whatever its remaining credit.
- R6: With top weights 1:1 and requests only from client 0 and the tail, successive grants alternate 0, tail, 0, tail.
- R7: After reset, take top weights local=1, lower=2 and level 1 weights 1:1, with clients 0, 1 and 2 requesting. Grants then repeat the cycle 1, 0, 2. Each level tracks a local credit and a lower credit, reloads both from the weights when both are zero and both sides are requesting, and picks the side with more credit, with ties going to the local side.
- R8: A client whose enable bit is low is never granted. Its share goes to the other side of its level.
- R9: When a level's own client is not requesting, the clients below it receive every grant, even if the local weight is larger.
- R10: When both clients of the shared level are requesting, the slot alternates between them, and the first grant after reset goes to the lower-numbered one.
- R11: With top weights 3:1 and requests from client 0 and the tail, the grants are 0, 0, 0, tail, repeating.
- R12: A weight change does not alter credits already loaded. It takes effect at the next reload of that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arbPoint | input | 1 | Arbitration-point strobe from the memory controller |
| clientReq | input | NUM_LEVELS+2 | Request line per client |
| clientEn | input | NUM_LEVELS+2 | Enable bit per client; a disabled client counts as weight 0 |
| localWeight | input | NUM_LEVELS x WEIGHT_W | Per-level weight of the level's own slot |
| lowerWeight | input | NUM_LEVELS x WEIGHT_W | Per-level weight of the branch below the level |
| grant | output | NUM_LEVELS+2 | Registered one-hot grant |
| grantValid | output | 1 | One-cycle pulse in the cycle after a strobe that granted a client |

## Verification
The properties assume the following about the inputs:
- Requests and enables matter only in the cycle where `arbPoint` is high.
- Reset is synchronous and held for at least one edge, so the grant register starts from a known zero.

The stimulus changes every input only on falling clock edges. It places strobes at random spacings, including back-to-back strobes. It keeps the weights within their 3-bit range, and it changes them while credits are partly used.

// File: rtl/hier_arb_pkg.sv
package hier_arb_pkg;

  // Per-level strobes from control to datapath.
  typedef struct packed {
    logic reload;     // load both credits from the weights before use
    logic takeLocal;  // spend one local credit
    logic takeLower;  // spend one lower-branch credit
  } lvlStrobe_t;

  // Strobes that act on the whole block.
  typedef struct packed {
    logic loadGrant;  // capture a new grant vector
    logic flipTurn;   // swap the turn at the shared level
  } topStrobe_t;

endpackage

// File: rtl/hier_arb_ctrl.sv
module hier_arb_ctrl
  import hier_arb_pkg::*;
#(
  parameter int NUM_LEVELS   = 3,
  parameter int SHARED_LEVEL = 2,
  parameter int WEIGHT_W     = 3,
  localparam int NUM_CLIENTS = NUM_LEVELS + 2
)(
  input  logic                                 arbPoint,
  input  logic [NUM_CLIENTS-1:0]               reqEff,
  input  logic [NUM_LEVELS-1:0][WEIGHT_W-1:0]  localWeight,
  input  logic [NUM_LEVELS-1:0][WEIGHT_W-1:0]  lowerWeight,
  input  logic [NUM_LEVELS-1:0][WEIGHT_W-1:0]  creditLoc,
  input  logic [NUM_LEVELS-1:0][WEIGHT_W-1:0]  creditLow,
  input  logic                                 partnerTurn,
  output lvlStrobe_t [NUM_LEVELS-1:0]          lvlStb,
  output topStrobe_t                           topStb,
  output logic [NUM_CLIENTS-1:0]               nextGrant
);

  localparam int PARTNER = NUM_LEVELS;
  localparam int TAIL    = NUM_LEVELS + 1;

  logic [NUM_LEVELS-1:0] localAny;
  logic [NUM_LEVELS-1:0] lowerAny;

  // Demand at each level's own slot.
  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_local
    if (i == SHARED_LEVEL) begin : g_pair
      assign localAny[i] = reqEff[i] | reqEff[PARTNER];
    end else begin : g_single
      assign localAny[i] = reqEff[i];
    end
  end

  // Demand anywhere below each level, built from the bottom up.
  always_comb begin
    lowerAny[NUM_LEVELS-1] = reqEff[TAIL];
    for (int i = NUM_LEVELS - 2; i >= 0; i--) begin
      lowerAny[i] = localAny[i+1] | lowerAny[i+1];
    end
  end

  // Walk down the chain from the top. A level is reached only when every
  // level above it handed the decision to its lower branch.
  always_comb begin
    logic                onPath;
    logic                both;
    logic                reload;
    logic                pickLocal;
    logic [WEIGHT_W-1:0] cl;
    logic [WEIGHT_W-1:0] cw;
    onPath           = 1'b1;
    nextGrant        = '0;
    topStb.loadGrant = arbPoint;
    topStb.flipTurn  = 1'b0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      lvlStb[i] = '0;
      both      = localAny[i] & lowerAny[i];
      reload    = both && (creditLoc[i] == '0) && (creditLow[i] == '0);
      cl        = reload ? localWeight[i] : creditLoc[i];
      cw        = reload ? lowerWeight[i] : creditLow[i];
      pickLocal = localAny[i] && (!lowerAny[i] || (cl >= cw));
      if (onPath) begin
        if (arbPoint) begin
          lvlStb[i].reload    = reload;
          lvlStb[i].takeLocal = both && pickLocal && (cl != '0);
          lvlStb[i].takeLower = both && !pickLocal && (cw != '0);
        end
        if (pickLocal) begin
          if (i == SHARED_LEVEL && reqEff[PARTNER] && (!reqEff[i] || partnerTurn)) begin
            nextGrant[PARTNER] = 1'b1;
          end else begin
            nextGrant[i] = 1'b1;
          end
          if (i == SHARED_LEVEL) begin
            topStb.flipTurn = arbPoint && reqEff[i] && reqEff[PARTNER];
          end
        end
      end
      onPath = onPath && !pickLocal && lowerAny[i];
    end
    if (onPath) begin
      nextGrant[TAIL] = 1'b1;
    end
  end

endmodule

// File: rtl/hier_arb_dp.sv
module hier_arb_dp
  import hier_arb_pkg::*;
#(
  parameter int NUM_LEVELS   = 3,
  parameter int WEIGHT_W     = 3,
  localparam int NUM_CLIENTS = NUM_LEVELS + 2
)(
  input  logic                                 clk,
  input  logic                                 rst,
  input  lvlStrobe_t [NUM_LEVELS-1:0]          lvlStb,
  input  topStrobe_t                           topStb,
  input  logic [NUM_CLIENTS-1:0]               nextGrant,
  input  logic [NUM_LEVELS-1:0][WEIGHT_W-1:0]  localWeight,
  input  logic [NUM_LEVELS-1:0][WEIGHT_W-1:0]  lowerWeight,
  output logic [NUM_LEVELS-1:0][WEIGHT_W-1:0]  creditLoc,
  output logic [NUM_LEVELS-1:0][WEIGHT_W-1:0]  creditLow,
  output logic                                 partnerTurn,
  output logic [NUM_CLIENTS-1:0]               grant,
  output logic                                 grantValid
);

  // Credit pair per level: optional reload, then spend one.
  always_ff @(posedge clk) begin
    if (rst) begin
      creditLoc <= '0;
      creditLow <= '0;
    end else begin
      for (int i = 0; i < NUM_LEVELS; i++) begin
        creditLoc[i] <= (lvlStb[i].reload ? localWeight[i] : creditLoc[i])
                        - WEIGHT_W'(lvlStb[i].takeLocal);
        creditLow[i] <= (lvlStb[i].reload ? lowerWeight[i] : creditLow[i])
                        - WEIGHT_W'(lvlStb[i].takeLower);
      end
    end
  end

  // Turn bit of the shared slot and the registered grant.
  always_ff @(posedge clk) begin
    if (rst) begin
      partnerTurn <= 1'b0;
      grant       <= '0;
      grantValid  <= 1'b0;
    end else begin
      if (topStb.flipTurn) begin
        partnerTurn <= ~partnerTurn;
      end
      if (topStb.loadGrant) begin
        grant <= nextGrant;
      end
      grantValid <= topStb.loadGrant && (|nextGrant);
    end
  end

endmodule

// File: rtl/hier_arb.sv
module hier_arb
  import hier_arb_pkg::*;
#(
  parameter int NUM_LEVELS   = 3,
  parameter int SHARED_LEVEL = 2,
  parameter int WEIGHT_W     = 3
)(
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                arbPoint,
  input  logic [NUM_LEVELS+1:0]               clientReq,
  input  logic [NUM_LEVELS+1:0]               clientEn,
  input  logic [NUM_LEVELS-1:0][WEIGHT_W-1:0] localWeight,
  input  logic [NUM_LEVELS-1:0][WEIGHT_W-1:0] lowerWeight,
  output logic [NUM_LEVELS+1:0]               grant,
  output logic                                grantValid
);

  localparam int NUM_CLIENTS = NUM_LEVELS + 2;

  logic [NUM_CLIENTS-1:0]              reqEff;
  logic [NUM_CLIENTS-1:0]              nextGrant;
  logic [NUM_LEVELS-1:0][WEIGHT_W-1:0] creditLoc;
  logic [NUM_LEVELS-1:0][WEIGHT_W-1:0] creditLow;
  logic                                partnerTurn;
  lvlStrobe_t [NUM_LEVELS-1:0]         lvlStb;
  topStrobe_t                          topStb;

  // A disabled client behaves as a weight of zero: it never competes.
  assign reqEff = clientReq & clientEn;

  hier_arb_ctrl #(
    .NUM_LEVELS  (NUM_LEVELS),
    .SHARED_LEVEL(SHARED_LEVEL),
    .WEIGHT_W    (WEIGHT_W)
  ) u_ctrl (
    .arbPoint   (arbPoint),
    .reqEff     (reqEff),
    .localWeight(localWeight),
    .lowerWeight(lowerWeight),
    .creditLoc  (creditLoc),
    .creditLow  (creditLow),
    .partnerTurn(partnerTurn),
    .lvlStb     (lvlStb),
    .topStb     (topStb),
    .nextGrant  (nextGrant)
  );

  hier_arb_dp #(
    .NUM_LEVELS(NUM_LEVELS),
    .WEIGHT_W  (WEIGHT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .lvlStb     (lvlStb),
    .topStb     (topStb),
    .nextGrant  (nextGrant),
    .localWeight(localWeight),
    .lowerWeight(lowerWeight),
    .creditLoc  (creditLoc),
    .creditLow  (creditLow),
    .partnerTurn(partnerTurn),
    .grant      (grant),
    .grantValid (grantValid)
  );

endmodule

// File: rtl/hier_arb_checker.sv
module hier_arb_checker #(
  parameter int NC = 5
)(
  input logic          clk,
  input logic          rst,
  input logic          arbPoint,
  input logic [NC-1:0] clientReq,
  input logic [NC-1:0] clientEn,
  input logic [NC-1:0] grant,
  input logic          grantValid
);

  // R2: without a strobe the grant holds.
  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !arbPoint |=> $stable(grant));

  // R2: a valid pulse always follows a strobe.
  a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    grantValid |-> $past(arbPoint));

  // R3: an idle strobe clears the grant.
  a_r3_idle_clears: assert property (@(posedge clk) disable iff (rst)
    (arbPoint && ((clientReq & clientEn) == '0)) |=> (grant == '0) && !grantValid);

  // R4: at most one client is granted.
  a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R4: the granted client was asking and enabled.
  a_r4_requested: assert property (@(posedge clk) disable iff (rst)
    arbPoint |=> (grant == '0) || ((grant & $past(clientReq & clientEn)) != '0));

  // R5: a lone requester wins outright.
  a_r5_single_wins: assert property (@(posedge clk) disable iff (rst)
    (arbPoint && ($countones(clientReq & clientEn) == 1))
      |=> grant == $past(clientReq & clientEn));

  // R8: a disabled client is never granted.
  a_r8_disabled_never: assert property (@(posedge clk) disable iff (rst)
    arbPoint |=> (grant & ~$past(clientEn)) == '0);

endmodule

bind hier_arb hier_arb_checker #(.NC(NUM_LEVELS + 2)) u_check (
  .clk       (clk),
  .rst       (rst),
  .arbPoint  (arbPoint),
  .clientReq (clientReq),
  .clientEn  (clientEn),
  .grant     (grant),
  .grantValid(grantValid)
);

// File: tb/test_hier_arb.sv
module test_hier_arb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NL = 3;
  localparam int SH = 2;
  localparam int WW = 3;
  localparam int NC = NL + 2;
  localparam int PARTNER = NL;
  localparam int TAIL = NL + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arbPoint = 1'b0;
  logic [NC-1:0] clientReq = '0;
  logic [NC-1:0] clientEn = '1;
  logic [NL-1:0][WW-1:0] localWeight = '0;
  logic [NL-1:0][WW-1:0] lowerWeight = '0;
  logic [NC-1:0] grant;
  logic grantValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string curTag = "R1";

  // Behavioural reference state.
  int mLoc[NL];
  int mLow[NL];
  bit mTurn = 1'b0;
  logic [NC-1:0] mGrant = '0;
  logic mValid = 1'b0;
  logic [NC-1:0] mPick;

  always #4 clk = ~clk;

  hier_arb #(.NUM_LEVELS(NL), .SHARED_LEVEL(SH), .WEIGHT_W(WW)) i_hier_arb (
    .clk(clk), .rst(rst), .arbPoint(arbPoint), .clientReq(clientReq),
    .clientEn(clientEn), .localWeight(localWeight), .lowerWeight(lowerWeight),
    .grant(grant), .grantValid(grantValid)
  );

  function automatic bit belowHas(logic [NC-1:0] r, int lvl);
    bit hit = r[TAIL];
    for (int k = lvl + 1; k < NL; k++) hit |= r[k];
    if (SH > lvl) hit |= r[PARTNER];
    return hit;
  endfunction

  task automatic modelPick(output logic [NC-1:0] g);
    logic [NC-1:0] r;
    int lvl;
    bit hasLoc, hasLow, goLocal;
    r = clientReq & clientEn;
    g = '0;
    lvl = 0;
    while (lvl < NL) begin
      hasLoc = r[lvl] || (lvl == SH && r[PARTNER]);
      hasLow = belowHas(r, lvl);
      if (!hasLoc && !hasLow) return;
      goLocal = hasLoc;
      if (hasLoc && hasLow) begin
        if (mLoc[lvl] == 0 && mLow[lvl] == 0) begin
          mLoc[lvl] = int'(localWeight[lvl]);
          mLow[lvl] = int'(lowerWeight[lvl]);
        end
        goLocal = (mLoc[lvl] >= mLow[lvl]);
        if (goLocal && mLoc[lvl] > 0) mLoc[lvl]--;
        if (!goLocal) mLow[lvl]--;
      end
      if (goLocal) begin
        if (lvl == SH && r[PARTNER] && r[lvl]) begin
          if (mTurn) g[PARTNER] = 1'b1; else g[lvl] = 1'b1;
          mTurn = !mTurn;
        end else if (lvl == SH && r[PARTNER]) begin
          g[PARTNER] = 1'b1;
        end else begin
          g[lvl] = 1'b1;
        end
        return;
      end
      lvl++;
    end
    if (r[TAIL]) g[TAIL] = 1'b1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) begin mLoc[i] = 0; mLow[i] = 0; end
      mTurn = 1'b0;
      mGrant = '0;
      mValid = 1'b0;
    end else begin
      mValid = 1'b0;
      if (arbPoint) begin
        modelPick(mPick);
        mGrant = mPick;
        mValid = |mPick;
      end
    end
  end

  task automatic check(string tag, logic [NC-1:0] got, logic [NC-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  // One cycle: compare against the reference at the falling edge.
  task automatic step();
    @(negedge clk);
    check({curTag, " grant vs model"}, grant, mGrant);
    check({curTag, " valid vs model"}, NC'(grantValid), NC'(mValid));
  endtask

  task automatic pulse();
    step();
    arbPoint = 1'b1;
    step();
    arbPoint = 1'b0;
  endtask

  task automatic pulseExpect(string tag, int idx);
    pulse();
    check(tag, grant, NC'(1) << idx);
    check({tag, " valid"}, NC'(grantValid), NC'(1));
  endtask

  task automatic doReset();
    rst = 1'b1;
    arbPoint = 1'b0;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic setW(int lvl, int wl, int wd);
    localWeight[lvl] = WW'(wl);
    lowerWeight[lvl] = WW'(wd);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seqA[6] = '{1, 0, 2, 1, 0, 2};
    int seqB[6] = '{0, 0, 4, 4, 4, 0};
    logic [NC-1:0] held;

    // R1: reset state.
    curTag = "R1";
    doReset();
    step();
    check("R1 grant after reset", grant, '0);
    check("R1 valid after reset", NC'(grantValid), '0);

    // R7: one-third split, cycle 1, 0, 2.
    curTag = "R7";
    setW(0, 1, 2); setW(1, 1, 1); setW(2, 1, 1);
    clientReq = 5'b00111;
    doReset();
    for (int k = 0; k < 6; k++) pulseExpect("R7 thirds order", seqA[k]);

    // R6: equal top weights alternate.
    curTag = "R6";
    setW(0, 1, 1);
    clientReq = 5'b10001;
    doReset();
    for (int k = 0; k < 4; k++) pulseExpect("R6 half split", (k % 2 == 0) ? 0 : TAIL);

    // R11: 3:1 weights.
    curTag = "R11";
    setW(0, 3, 1);
    doReset();
    for (int k = 0; k < 8; k++) pulseExpect("R11 three to one", (k % 4 == 3) ? TAIL : 0);

    // R12: a weight change waits for the next reload.
    curTag = "R12";
    doReset();
    pulseExpect("R12 before change", 0);
    setW(0, 1, 3);
    for (int k = 0; k < 6; k++) pulseExpect("R12 after change", seqB[k]);

    // R2: the grant holds between strobes; valid is a single pulse.
    curTag = "R2";
    pulse();
    held = grant;
    check("R2 valid after strobe", NC'(grantValid), NC'(1));
    clientReq = 5'b01110;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R2 grant held", grant, held);
      check("R2 valid low", NC'(grantValid), '0);
    end

    // R10: shared-level pair alternates.
    curTag = "R10";
    setW(0, 7, 1); setW(1, 7, 1);
    clientReq = 5'b01100;
    doReset();
    for (int k = 0; k < 4; k++) pulseExpect("R10 shared turn", (k % 2 == 0) ? 2 : PARTNER);

    // R5: a lone requester wins against large opposing weights.
    curTag = "R5";
    setW(0, 7, 0); setW(1, 7, 0);
    clientReq = 5'b00100;
    pulseExpect("R5 lone mid client", 2);
    clientReq = 5'b10000;
    pulseExpect("R5 lone tail client", TAIL);

    // R9: unused top share flows down.
    curTag = "R9";
    setW(0, 7, 1); setW(1, 1, 1);
    clientReq = 5'b11110;
    doReset();
    for (int k = 0; k < 4; k++) begin
      pulse();
      check("R9 top idle never granted", grant & 5'b00001, '0);
      check("R9 grant present", NC'(grantValid), NC'(1));
    end

    // R8: disabled client gets nothing.
    curTag = "R8";
    clientReq = 5'b11111;
    clientEn = 5'b11110;
    for (int k = 0; k < 4; k++) begin
      pulse();
      check("R8 disabled never granted", grant & 5'b00001, '0);
      check("R8 grant present", NC'(grantValid), NC'(1));
    end
    clientEn = '1;

    // R3: an idle strobe clears the grant.
    curTag = "R3";
    clientReq = '0;
    pulse();
    check("R3 idle grant", grant, '0);
    check("R3 idle valid", NC'(grantValid), '0);

    // R4: mixed traffic against the reference model.
    curTag = "R4";
    for (int k = 0; k < 3000; k++) begin
      step();
      if (!$onehot0(grant)) check("R4 onehot", grant, '0);
      clientReq = NC'($urandom);
      clientEn = ($urandom % 4 == 0) ? NC'($urandom) : '1;
      arbPoint = ($urandom % 3 == 0);
      if ($urandom % 50 == 0) begin
        int lv = int'($urandom % NL);
        setW(lv, int'($urandom % 8), int'($urandom % 8));
      end
    end
    arbPoint = 1'b0;
    step();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule